// File: doc/BRIEF.md
# Semi-global path cost aggregator with winner-take-all

This block takes one vector of matching costs per pixel, one cost for each candidate disparity, in raster order. Along each enabled scan direction it applies the semi-global smoothness recurrence. Moving to a neighbouring disparity costs a small penalty. A larger jump costs a big penalty. Each path result is normalised by subtracting the minimum of the previous path vector. The block adds the path results together and reports the disparity with the lowest total.

The two penalties come in on ports, so software can retune them between frames. A parameter picks the path set:
- 1: left to right only.
- 2: adds top to bottom.
- 4: adds the two upper diagonals.

Every path looks back only at pixels already seen in raster order, so one pass over the frame is enough. The block keeps a one-vector register for the horizontal path and a line of vectors for each vertical or diagonal path.

Top module: `sgm_aggregator`

## Requirements
- R1: For each enabled path, the path cost at disparity d equals C(d) + min(Lp(d), Lp(d-1)+P1, Lp(d+1)+P1, minLp+P2) - minLp. Here Lp is the path vector at the previous pixel along that path, and minLp is its minimum over all disparities.
- R2: The penalty `pen_small` applies only to a step of one disparity and `pen_large` to any larger step. At d=0 the d-1 term is left out, and at d=NDISP-1 the d+1 term is left out.
- R3: When the previous pixel along a path lies outside the frame, that path's cost equals the raw matching cost. This covers the first column for the horizontal path, the first row for the vertical path, and first row or column for the left diagonal. It also covers the first row or last column for the right diagonal.
- R4: NPATH=1 uses only the left-to-right path. NPATH=2 adds top-to-bottom. NPATH=4 adds the paths from the upper-left and from the upper-right neighbour.
- R5: The costs of all enabled paths are added per disparity to form the total cost.
- R6: `out_disp` is the index of the smallest total cost. On a tie the lowest index wins.
- R7: Each cycle with `in_valid` high produces exactly one result with `out_valid` high on the next cycle. `out_valid` is low after a cycle without input, and `out_disp` then holds its value.
- R8: Pixels are taken in raster order over IMG_W x IMG_H. After the last pixel the position returns to the frame start, so the next frame begins with the R3 edge rules.
- R9: Reset drives `out_valid` low and returns the position to the frame start, even mid-frame.
- R10: Path costs and totals never wrap, even with every cost and both penalties at their largest values. Path cost width is max(COST_W, PEN_W)+1 bits, and the total is widened by log2(NPATH).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pen_small | input | PEN_W | Penalty for a one-disparity step |
| pen_large | input | PEN_W | Penalty for a jump of more than one disparity |
| in_valid | input | 1 | A cost vector is present this cycle |
| in_cost | input | NDISP*COST_W | Cost vector; disparity d sits in bits [d*COST_W +: COST_W] |
| out_valid | output | 1 | A disparity result is present |
| out_disp | output | $clog2(NDISP) | Winning disparity index |

## Verification
Some faults live only in stored state: a stale horizontal register, a line entry written to the wrong column, or the diagonal hold register slipping by one. These show up as a wrong `out_disp` starting at the first pixel whose recurrence reads the faulty vector. That is the second pixel of a row, or the first pixels of the second row. The error then spreads along that path for the rest of the frame. A broken position counter shows up at the next row or frame boundary: edge pixels stop being treated as path starts, and the disparities differ there. Every cycle is compared against an independent model, so a fault is reported within one output cycle of its first visible effect.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
   // Scan directions in the order the path parameter enables them
   typedef enum int {
      DIR_LEFT   = 0,
      DIR_TOP    = 1,
      DIR_TOPL   = 2,
      DIR_TOPR   = 3
   } sgm_dir_e;

   function automatic int path_width(input int cost_w, input int pen_w);
      return ((cost_w > pen_w) ? cost_w : pen_w) + 1;
   endfunction
endpackage

// File: rtl/sgm_path_step.sv
module sgm_path_step #(
   parameter int NDISP  = 16,
   parameter int COST_W = 8,
   parameter int PEN_W  = 8,
   parameter int LW     = 9
) (
   input  logic                    prev_ok,
   input  logic [NDISP*LW-1:0]     prev_vec,
   input  logic [NDISP*COST_W-1:0] cost_vec,
   input  logic [PEN_W-1:0]        p1,
   input  logic [PEN_W-1:0]        p2,
   output logic [NDISP*LW-1:0]     new_vec
);
   localparam int EW = LW + 2;

   logic [EW-1:0] mn, best, term, cur;
   int            dm, dp;

   always_comb begin
      mn = {EW{1'b1}};
      for (int d = 0; d < NDISP; d++)
         if (EW'(prev_vec[d*LW +: LW]) < mn) mn = EW'(prev_vec[d*LW +: LW]);
      new_vec = '0;
      best    = '0;
      term    = '0;
      for (int d = 0; d < NDISP; d++) begin
         cur = EW'(cost_vec[d*COST_W +: COST_W]);
         dm  = (d > 0) ? d - 1 : 0;
         dp  = (d < NDISP - 1) ? d + 1 : d;
         if (!prev_ok) begin
            new_vec[d*LW +: LW] = cur[LW-1:0];
         end else begin
            best = EW'(prev_vec[d*LW +: LW]);
            if (d > 0) begin
               term = EW'(prev_vec[dm*LW +: LW]) + EW'(p1);
               if (term < best) best = term;
            end
            if (d < NDISP - 1) begin
               term = EW'(prev_vec[dp*LW +: LW]) + EW'(p1);
               if (term < best) best = term;
            end
            term = mn + EW'(p2);
            if (term < best) best = term;
            new_vec[d*LW +: LW] = LW'(cur + best - mn);
         end
      end
   end
endmodule

// File: rtl/sgm_argmin.sv
module sgm_argmin #(
   parameter int NDISP  = 16,
   parameter int SW     = 11,
   parameter int DISP_W = 4
) (
   input  logic [NDISP*SW-1:0] sum_vec,
   output logic [DISP_W-1:0]   idx
);
   logic [SW-1:0] bestv;

   always_comb begin
      bestv = sum_vec[0 +: SW];
      idx   = '0;
      // strict compare keeps the lowest index on a tie
      for (int d = 1; d < NDISP; d++)
         if (sum_vec[d*SW +: SW] < bestv) begin
            bestv = sum_vec[d*SW +: SW];
            idx   = DISP_W'(d);
         end
   end
endmodule

// File: rtl/sgm_aggregator.sv
module sgm_aggregator #(
   parameter int NDISP  = 16,
   parameter int COST_W = 8,
   parameter int PEN_W  = 8,
   parameter int IMG_W  = 272,
   parameter int IMG_H  = 240,
   parameter int NPATH  = 4,
   localparam int DISP_W = $clog2(NDISP)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PEN_W-1:0]        pen_small,
   input  logic [PEN_W-1:0]        pen_large,
   input  logic                    in_valid,
   input  logic [NDISP*COST_W-1:0] in_cost,
   output logic                    out_valid,
   output logic [DISP_W-1:0]       out_disp
);
   import sgm_pkg::*;

   localparam int LW = path_width(COST_W, PEN_W);
   localparam int SW = LW + $clog2(NPATH);
   localparam int VW = NDISP * LW;
   localparam int XW = $clog2(IMG_W);
   localparam int YW = $clog2(IMG_H);
   localparam logic [XW-1:0] XLAST = XW'(IMG_W - 1);
   localparam logic [YW-1:0] YLAST = YW'(IMG_H - 1);

   if (!(NPATH == 1 || NPATH == 2 || NPATH == 4)) begin : g_bad_npath
      $error("sgm_aggregator: NPATH must be 1, 2 or 4");
   end
   if (NDISP < 2 || (1 << DISP_W) != NDISP) begin : g_bad_ndisp
      $error("sgm_aggregator: NDISP must be a power of two, at least 2");
   end
   if (IMG_W < 2 || IMG_H < 2) begin : g_bad_frame
      $error("sgm_aggregator: frame must be at least 2x2");
   end

   logic [XW-1:0]             col_q;
   logic [YW-1:0]             row_q;
   logic [NPATH-1:0]          prev_ok;
   logic [NPATH-1:0][VW-1:0]  prev_vec;
   logic [NPATH-1:0][VW-1:0]  new_vec;
   logic [NDISP*SW-1:0]       sum_vec;
   logic [SW-1:0]             acc;
   logic [DISP_W-1:0]         win_idx;

   // raster position of the pixel being accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (in_valid) begin
         if (col_q == XLAST) begin
            col_q <= '0;
            row_q <= (row_q == YLAST) ? '0 : row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      sgm_path_step #(
         .NDISP(NDISP), .COST_W(COST_W), .PEN_W(PEN_W), .LW(LW)
      ) u_step (
         .prev_ok (prev_ok[p]),
         .prev_vec(prev_vec[p]),
         .cost_vec(in_cost),
         .p1      (pen_small),
         .p2      (pen_large),
         .new_vec (new_vec[p])
      );

      if (p == int'(DIR_LEFT)) begin : g_left
         logic [VW-1:0] hreg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hreg <= '0;
            else if (in_valid) hreg <= new_vec[p];
         end
         assign prev_vec[p] = hreg;
         assign prev_ok[p]  = (col_q != '0);
      end else if (p == int'(DIR_TOP)) begin : g_top
         logic [VW-1:0] line [IMG_W];
         always_ff @(posedge clk) begin
            if (in_valid) line[col_q] <= new_vec[p];
         end
         assign prev_vec[p] = line[col_q];
         assign prev_ok[p]  = (row_q != '0);
      end else if (p == int'(DIR_TOPL)) begin : g_topl
         logic [VW-1:0] line [IMG_W];
         logic [VW-1:0] held;
         // held keeps the upper-row entry of the column just overwritten
         always_ff @(posedge clk) begin
            if (in_valid) begin
               line[col_q] <= new_vec[p];
               held        <= line[col_q];
            end
         end
         assign prev_vec[p] = held;
         assign prev_ok[p]  = (col_q != '0) && (row_q != '0);
      end else begin : g_topr
         logic [VW-1:0] line [IMG_W];
         logic [XW-1:0] nx;
         assign nx = (col_q == XLAST) ? col_q : col_q + 1'b1;
         always_ff @(posedge clk) begin
            if (in_valid) line[col_q] <= new_vec[p];
         end
         assign prev_vec[p] = line[nx];
         assign prev_ok[p]  = (row_q != '0) && (col_q != XLAST);
      end
   end

   always_comb begin
      sum_vec = '0;
      for (int d = 0; d < NDISP; d++) begin
         acc = '0;
         for (int p = 0; p < NPATH; p++)
            acc = acc + SW'(new_vec[p][d*LW +: LW]);
         sum_vec[d*SW +: SW] = acc;
      end
   end

   sgm_argmin #(.NDISP(NDISP), .SW(SW), .DISP_W(DISP_W)) u_wta (
      .sum_vec(sum_vec),
      .idx    (win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_disp  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_disp <= win_idx;
      end
   end
endmodule

// File: rtl/sgm_aggregator_chk.sv
module sgm_aggregator_chk #(
   parameter int IMG_W  = 272,
   parameter int XW     = 9,
   parameter int DISP_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [XW-1:0]     col,
   input logic              out_valid,
   input logic [DISP_W-1:0] out_disp
);
   // R7
   result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R7
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R7
   disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_disp));
   // R8
   col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && col == XW'(IMG_W - 1)) |=> (col == '0));
   // R8
   col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(col) < IMG_W);
endmodule

bind sgm_aggregator sgm_aggregator_chk #(
   .IMG_W(IMG_W), .XW(XW), .DISP_W(DISP_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .col      (col_q),
   .out_valid(out_valid),
   .out_disp (out_disp)
);

// File: tb/sim_sgm_aggregator.sv
module sim_sgm_aggregator;
   localparam int CLK_PERIOD = 10;
   localparam int NDISP  = 8;
   localparam int COST_W = 6;
   localparam int PEN_W  = 6;
   localparam int IMG_W  = 6;
   localparam int IMG_H  = 4;
   localparam int DW     = $clog2(NDISP);
   localparam int CMAX   = (1 << COST_W) - 1;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [PEN_W-1:0]        pen_small = '0;
   logic [PEN_W-1:0]        pen_large = '0;
   logic                    in_valid = 1'b0;
   logic [NDISP*COST_W-1:0] in_cost = '0;
   logic                    o0_v, o1_v;
   logic [DW-1:0]           o0_d, o1_d;

   int checks = 0;
   int errors = 0;
   int last0 = 0, last1 = 0;
   int cst [IMG_H][IMG_W][NDISP];
   int lp  [4][IMG_H][IMG_W][NDISP];
   int e4  [IMG_H][IMG_W];
   int e1  [IMG_H][IMG_W];

   always #(CLK_PERIOD/2) clk = ~clk;

   sgm_aggregator #(.NDISP(NDISP), .COST_W(COST_W), .PEN_W(PEN_W),
      .IMG_W(IMG_W), .IMG_H(IMG_H), .NPATH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .pen_small(pen_small), .pen_large(pen_large),
      .in_valid(in_valid), .in_cost(in_cost), .out_valid(o0_v), .out_disp(o0_d));

   sgm_aggregator #(.NDISP(NDISP), .COST_W(COST_W), .PEN_W(PEN_W),
      .IMG_W(IMG_W), .IMG_H(IMG_H), .NPATH(1)) u1 (
      .clk(clk), .rst_n(rst_n), .pen_small(pen_small), .pen_large(pen_large),
      .in_valid(in_valid), .in_cost(in_cost), .out_valid(o1_v), .out_disp(o1_d));

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, got, exp);
      end
   endtask

   // reference: recurrence (R1, R2), path starts at frame edges (R3),
   // path sets (R4), per-disparity sum (R5), lowest-index argmin (R6)
   task automatic model(int p1, int p2);
      for (int y = 0; y < IMG_H; y++)
         for (int x = 0; x < IMG_W; x++) begin
            for (int p = 0; p < 4; p++) begin
               int py, px, mn;
               bit ok;
               py = (p == 0) ? y : y - 1;
               px = (p == 0 || p == 2) ? x - 1 : (p == 1) ? x : x + 1;
               ok = (py >= 0) && (px >= 0) && (px < IMG_W);
               mn = 1 << 30;
               if (ok)
                  for (int k = 0; k < NDISP; k++)
                     if (lp[p][py][px][k] < mn) mn = lp[p][py][px][k];
               for (int d = 0; d < NDISP; d++) begin
                  if (!ok) lp[p][y][x][d] = cst[y][x][d];
                  else begin
                     int b;
                     b = lp[p][py][px][d];
                     if (d > 0 && lp[p][py][px][d-1] + p1 < b) b = lp[p][py][px][d-1] + p1;
                     if (d < NDISP-1 && lp[p][py][px][d+1] + p1 < b) b = lp[p][py][px][d+1] + p1;
                     if (mn + p2 < b) b = mn + p2;
                     lp[p][y][x][d] = cst[y][x][d] + b - mn;
                  end
               end
            end
            begin
               int b4, b1;
               b4 = -1; b1 = -1;
               for (int d = 0; d < NDISP; d++) begin
                  int s4;
                  s4 = lp[0][y][x][d] + lp[1][y][x][d] + lp[2][y][x][d] + lp[3][y][x][d];
                  if (b4 < 0 || s4 < b4) begin b4 = s4; e4[y][x] = d; end
                  if (b1 < 0 || lp[0][y][x][d] < b1) begin b1 = lp[0][y][x][d]; e1[y][x] = d; end
               end
            end
         end
   endtask

   task automatic push(int y, int x, string tag);
      in_valid = 1'b1;
      for (int d = 0; d < NDISP; d++) in_cost[d*COST_W +: COST_W] = COST_W'(cst[y][x][d]);
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " R7 u0 valid"}, int'(o0_v), 1);
      chk({tag, " R5 four-path disparity"}, int'(o0_d), e4[y][x]);
      chk({tag, " R4 one-path disparity"}, int'(o1_d), e1[y][x]);
      last0 = e4[y][x];
      last1 = e1[y][x];
   endtask

   task automatic idle();
      in_valid = 1'b0;
      @(negedge clk);
      chk("R7 idle valid low", int'(o0_v | o1_v), 0);
      chk("R7 idle disp held", int'(o0_d), last0);
      chk("R7 idle disp held one-path", int'(o1_d), last1);
   endtask

   // frames run back to back: the position must wrap to the frame start (R8)
   task automatic run_frame(string tag, int p1, int p2);
      pen_small = PEN_W'(p1);
      pen_large = PEN_W'(p2);
      model(p1, p2);
      for (int y = 0; y < IMG_H; y++)
         for (int x = 0; x < IMG_W; x++) begin
            push(y, x, {tag, " R8"});
            if ($urandom_range(0, 3) == 0) idle();
         end
   endtask

   task automatic fill_random(int hi);
      for (int y = 0; y < IMG_H; y++)
         for (int x = 0; x < IMG_W; x++)
            for (int d = 0; d < NDISP; d++) cst[y][x][d] = int'($urandom_range(0, hi));
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R9 reset valid low", int'(o0_v | o1_v), 0);
      chk("R9 reset disp zero", int'(o0_d), 0);
      rst_n = 1'b1;
      @(negedge clk);

      fill_random(CMAX);
      run_frame("R1 random", 5, 25);

      for (int y = 0; y < IMG_H; y++)
         for (int x = 0; x < IMG_W; x++)
            for (int d = 0; d < NDISP; d++) cst[y][x][d] = 9;
      run_frame("R6 tie", 3, 10);

      fill_random(CMAX);
      for (int x = 0; x < IMG_W; x++)
         for (int d = 0; d < NDISP; d++) cst[1][x][d] = CMAX;
      run_frame("R10 saturating", (1 << PEN_W) - 1, (1 << PEN_W) - 1);

      // disparity step of one vs. a jump: P1 and P2 act differently (R2)
      for (int y = 0; y < IMG_H; y++)
         for (int x = 0; x < IMG_W; x++)
            for (int d = 0; d < NDISP; d++) begin
               int want;
               want = (x < 2) ? 0 : (x < 4) ? 1 : NDISP - 1;
               cst[y][x][d] = (d == want) ? 10 : (d == want + 1 ? 14 : 30 + d);
            end
      run_frame("R2 step", 6, 40);

      // reset in the middle of a frame restarts the position (R9)
      fill_random(CMAX);
      pen_small = 6'd4;
      pen_large = 6'd30;
      model(4, 30);
      for (int x = 0; x < 5; x++) push(0, x, "R9 pre-reset");
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 mid-frame reset valid low", int'(o0_v | o1_v), 0);
      rst_n = 1'b1;
      last0 = 0;
      last1 = 0;
      run_frame("R9 after reset", 4, 30);

      fill_random(20);
      run_frame("R3 zero penalty", 0, 0);

      fill_random(CMAX);
      run_frame("R1 mixed", 2, 50);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule